// File: doc/BRIEF.md
# Occupancy-Driven Read-Rate Controller FIFO

This block is a 16-entry synchronous buffer between a fast data producer and a slower filter consumer. The producer pushes words with a valid strobe. The buffer releases words toward the filter only in read slots, and a clock-enable pacer spaces those slots at one of four rates. A closed-loop detector looks at the fill level and at the balance of pushes and pops once per 16-cycle window. It then moves the read rate up or down by one step, so the buffer stays away from both full and empty.

The current rate level goes out on a port. It stands in for a clock-frequency or supply-voltage request to the consumer's domain. The full and empty flags are still produced. A sticky error flag records any dropped push or any starved read slot, which are the conditions the loop is meant to prevent.

The rate controller is a four-state machine: RATE_X8 (one read slot every 8 cycles, level 0), RATE_X4 (every 4, level 1), RATE_X2 (every 2, level 2) and RATE_X1 (every cycle, level 3). At each decision point one of three transitions is taken. STEP_UP moves to the next faster state. STEP_DOWN moves to the next slower state. HOLD stays in place. HOLD is also taken at every cycle that is not a decision point, and whenever a step would leave the ends of the range.

Top module: `rate_ctl_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, rd_valid is 0, err_flag is 0 and rate_level is 0, the slowest rate.
- R2: Words leave in the order they were accepted. The buffer holds at most 16 words. empty is 1 exactly when 0 words are held, and full is 1 exactly when 16 words are held.
- R3: A push offered while full is dropped. It does not change the held contents.
- R4: A free-running 4-bit cycle counter starts at 0 after reset. A cycle is a read slot when the counter's low (3 - rate_level) bits are all zero, so slots come every 8, 4, 2 or 1 cycles. A slot with data held pops one word, and rd_valid with that word on rd_data appears in the next cycle.
- R5: A decision is taken only in the cycle where the cycle counter equals 15. rate_level changes only on the clock edge that ends that cycle, and by at most one step.
- R6: STEP_UP is taken when the held count is 12 or more, or when the count is above 4 and the window's push tally exceeds its pop tally.
- R7: STEP_DOWN is taken when the held count is 4 or fewer and the push tally does not exceed the pop tally.
- R8: STEP_UP at level 3 and STEP_DOWN at level 0 leave the level unchanged.
- R9: err_flag is set by a push offered while full, or by a read slot that finds the buffer empty while rate_level is above 0. Once set, it stays set until reset.
- R10: The push and pop tallies count accepted pushes and pops in the cycles after a decision cycle. They restart from zero after each decision, and the decision cycle's own events are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer offers a word this cycle |
| wr_data | input | 16 | Offered word |
| rd_valid | output | 1 | A word is delivered to the filter this cycle |
| rd_data | output | 16 | Delivered word |
| rate_level | output | 2 | Current read-rate level, 0 = slowest (every 8 cycles), 3 = every cycle |
| full | output | 1 | 16 words held |
| empty | output | 1 | No word held |
| err_flag | output | 1 | Sticky overflow or starvation indicator |

## Verification
A push or pop decided in cycle c shows on full and empty from cycle c+1. A read slot in cycle c gives rd_valid and rd_data in cycle c+1. A decision in the cycle where the counter is 15 shows on rate_level from the next cycle, which is when the counter reads 0. The bench keeps an arithmetic model that advances once per clock edge with the same inputs the design sees. It drives the inputs and compares every output on the falling edge, so each compare sees exactly the values the previous rising edge produced. The write patterns sweep the write spacing from 1 to 8 cycles, add bursts separated by idle gaps, and add a pseudo-random stream. Together these reach both ends of the rate range, full, empty and the error flag.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    typedef enum logic [1:0] {
        RATE_X8 = 2'd0,
        RATE_X4 = 2'd1,
        RATE_X2 = 2'd2,
        RATE_X1 = 2'd3
    } rate_state_t;

    // Low cycle-counter bits that must be zero for a read slot.
    function automatic logic [2:0] slot_mask(input rate_state_t s);
        logic [2:0] m;
        unique case (s)
            RATE_X8: m = 3'b111;
            RATE_X4: m = 3'b011;
            RATE_X2: m = 3'b001;
            RATE_X1: m = 3'b000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rcf_storage.sv
module rcf_storage #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty,
    output logic              push_done,
    output logic              pop_done
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign push_done = push_req && !full;
    assign pop_done  = pop_req && !empty;
    assign pop_data  = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_done) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_done) begin
                wptr <= wptr + 1'b1;
            end
            if (pop_done) begin
                rptr <= rptr + 1'b1;
            end
            unique case ({push_done, pop_done})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: occupancy never exceeds the depth
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R2: an empty buffer with no push stays empty
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push_req) |=> empty);

    // R3: a push while full with no pop leaves the count as it was
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req) |=> (count == $past(count)));

endmodule

// File: rtl/rcf_pacer.sv
module rcf_pacer
    import rcf_pkg::*;
#(
    parameter int unsigned EPOCH_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  rate_state_t rate,
    output logic        slot,
    output logic        decide
);

    logic [EPOCH_W-1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    assign slot   = ((cyc[2:0] & slot_mask(rate)) == 3'b000);
    assign decide = &cyc;

    // R5: decision points are never back to back
    assert_decide_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        decide |=> !decide);

    // R4: at the slowest rate two slots are never adjacent
    assert_slow_slot_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && rate == RATE_X8 && !decide) |=> !slot);

endmodule

// File: rtl/rcf_detector.sv
module rcf_detector
    import rcf_pkg::*;
#(
    parameter int unsigned CW      = 5,
    parameter int unsigned EPOCH_W = 4,
    parameter int unsigned HI_MARK = 12,
    parameter int unsigned LO_MARK = 4,
    localparam int unsigned TW     = EPOCH_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          decide,
    input  logic          push_done,
    input  logic          pop_done,
    input  logic [CW-1:0] count,
    output rate_state_t   rate,
    output logic [1:0]    level
);

    rate_state_t   state_q, state_d;
    logic [TW-1:0] wr_tally, rd_tally;
    logic          go_up, go_dn;

    // Tallies of accepted events since the last decision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_tally <= '0;
            rd_tally <= '0;
        end else if (decide) begin
            wr_tally <= '0;
            rd_tally <= '0;
        end else begin
            wr_tally <= wr_tally + TW'(push_done);
            rd_tally <= rd_tally + TW'(pop_done);
        end
    end

    assign go_up = (count >= CW'(HI_MARK))
                || ((count > CW'(LO_MARK)) && (wr_tally > rd_tally));
    assign go_dn = (count <= CW'(LO_MARK)) && (wr_tally <= rd_tally);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RATE_X8;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: STEP_UP, STEP_DOWN, HOLD.
    always_comb begin
        state_d = state_q;
        if (decide) begin
            unique case (state_q)
                RATE_X8: if (go_up) state_d = RATE_X4;
                RATE_X4: if (go_up) state_d = RATE_X2;
                         else if (go_dn) state_d = RATE_X8;
                RATE_X2: if (go_up) state_d = RATE_X1;
                         else if (go_dn) state_d = RATE_X4;
                RATE_X1: if (go_dn) state_d = RATE_X2;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        rate  = state_q;
        level = 2'(state_q);
    end

    // R5: level is held between decision points
    assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !decide |=> $stable(state_q));

    // R5: a decision moves the level by at most one step
    assert_step_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        decide |=> ((int'(state_q) - int'($past(state_q))) inside {-1, 0, 1}));

    // R10: tallies restart after each decision
    assert_tally_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        decide |=> (wr_tally == '0 && rd_tally == '0));

endmodule

// File: rtl/rate_ctl_fifo.sv
module rate_ctl_fifo
    import rcf_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned HI_MARK = 12,
    parameter int unsigned LO_MARK = 4,
    parameter int unsigned EPOCH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rate_level,
    output logic              full,
    output logic              empty,
    output logic              err_flag
);

    localparam int unsigned CW = $clog2(DEPTH) + 1;

    logic [DATA_W-1:0] pop_data;
    logic [CW-1:0]     count;
    logic              push_done, pop_done, slot, decide;
    logic              err_event;
    rate_state_t       rate;

    rcf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) storage_i (
        .clk(clk), .rst_n(rst_n),
        .push_req(wr_valid), .push_data(wr_data),
        .pop_req(slot), .pop_data(pop_data),
        .count(count), .full(full), .empty(empty),
        .push_done(push_done), .pop_done(pop_done)
    );

    rcf_pacer #(.EPOCH_W(EPOCH_W)) pacer_i (
        .clk(clk), .rst_n(rst_n), .rate(rate),
        .slot(slot), .decide(decide)
    );

    rcf_detector #(
        .CW(CW), .EPOCH_W(EPOCH_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
    ) detector_i (
        .clk(clk), .rst_n(rst_n), .decide(decide),
        .push_done(push_done), .pop_done(pop_done), .count(count),
        .rate(rate), .level(rate_level)
    );

    assign err_event = (wr_valid && full) || (slot && empty && rate != RATE_X8);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            err_flag <= 1'b0;
        end else begin
            rd_valid <= pop_done;
            if (pop_done) begin
                rd_data <= pop_data;
            end
            if (err_event) begin
                err_flag <= 1'b1;
            end
        end
    end

    // R9: the error flag never clears without reset
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R4: delivery only follows a read slot
    assert_delivery_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(slot));

    // R3: a push offered while full raises the error flag
    assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full) |=> err_flag);

endmodule

// File: tb/rate_ctl_fifo_tb_top.sv
module rate_ctl_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_valid, full, empty, err_flag;
    logic [15:0] rd_data;
    logic [1:0]  rate_level;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // Reference state
    logic [15:0] ref_q[$];
    int          ref_lvl, ref_cyc, ref_wacc, ref_racc;
    logic        ref_rv, ref_err;
    logic [15:0] ref_rd;
    string       ref_tag;
    logic [15:0] next_data;

    always #4 clk = ~clk;

    rate_ctl_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .rate_level(rate_level),
        .full(full), .empty(empty), .err_flag(err_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic ref_reset();
        ref_q.delete();
        ref_lvl = 0; ref_cyc = 0; ref_wacc = 0; ref_racc = 0;
        ref_rv = 0; ref_err = 0; ref_rd = '0; ref_tag = "R5";
    endtask

    task automatic ref_advance(input logic wv, input logic [15:0] wd);
        int  sz, mask;
        bit  is_full, is_empty, slot_now, push, pop, dec, up, dn;
        sz       = ref_q.size();
        is_full  = (sz == 16);
        is_empty = (sz == 0);
        mask     = (8 >> ref_lvl) - 1;
        slot_now = (((ref_cyc % 8) & mask) == 0);
        push     = wv && !is_full;
        pop      = slot_now && !is_empty;
        dec      = (ref_cyc == 15);
        up       = (sz >= 12) || (sz > 4 && ref_wacc > ref_racc);
        dn       = (sz <= 4) && (ref_wacc <= ref_racc);
        if ((wv && is_full) || (slot_now && is_empty && ref_lvl != 0)) ref_err = 1;
        ref_rv = pop;
        if (pop) ref_rd = ref_q.pop_front();
        if (push) ref_q.push_back(wd);
        ref_tag = "R5";
        if (dec) begin
            ref_tag = "R10";
            if (up) begin
                if (ref_lvl < 3) begin ref_lvl++; ref_tag = "R6"; end
                else ref_tag = "R8";
            end else if (dn) begin
                if (ref_lvl > 0) begin ref_lvl--; ref_tag = "R7"; end
                else ref_tag = "R8";
            end
            ref_wacc = 0; ref_racc = 0;
        end else begin
            ref_wacc += int'(push);
            ref_racc += int'(pop);
        end
        ref_cyc = (ref_cyc + 1) % 16;
    endtask

    task automatic compare();
        check("R4 rd_valid", int'(rd_valid), int'(ref_rv));
        if (ref_rv) check("R2 order rd_data", int'(rd_data), int'(ref_rd));
        check({ref_tag, " rate_level"}, int'(rate_level), ref_lvl);
        check("R3 full", int'(full), int'(ref_q.size() == 16));
        check("R2 empty", int'(empty), int'(ref_q.size() == 0));
        check("R9 err_flag", int'(err_flag), int'(ref_err));
    endtask

    task automatic step(input logic wv);
        compare();
        wr_valid = wv;
        wr_data  = next_data;
        ref_advance(wv, next_data);
        if (wv) next_data++;
        @(negedge clk);
        cycles++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ref_reset();
        // R1: reset state
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 err_flag", int'(err_flag), 0);
        check("R1 rate_level", int'(rate_level), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stimulus
        logic [15:0] lfsr;
        next_data = 16'h0100;
        // Sweep of write spacing 1..8 (R2, R3, R4, R6, R7, R8, R9)
        for (int p = 1; p <= 8; p++) begin
            do_reset();
            for (int k = 0; k < 320; k++) step((k % p) == 0);
            // drain phase with no writes
            for (int k = 0; k < 160; k++) step(1'b0);
        end
        // Bursts separated by idle gaps (R6, R7, R10)
        do_reset();
        for (int b = 0; b < 6; b++) begin
            for (int k = 0; k < 20 + 3 * b; k++) step(1'b1);
            for (int k = 0; k < 90; k++) step(1'b0);
        end
        // Pseudo-random stream, about 3 in 4 cycles (R2, R5)
        do_reset();
        lfsr = 16'hACE1;
        for (int k = 0; k < 1500; k++) begin
            step(lfsr[1:0] != 2'b00);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        // Error flag stays set while writes stop (R9)
        for (int k = 0; k < 64; k++) step(1'b0);
        // Reset clears everything again (R1)
        do_reset();
        step(1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule